// File: doc/BRIEF.md
# Segmented Refresh Scheduler for a Split-Field Activation Buffer

This block schedules row refreshes for an embedded DRAM buffer that holds bfloat16 activations. Every stored word is split over two physical segments. The sign-and-exponent segment holds the sign and the 8-bit exponent. The mantissa segment holds the 7-bit fraction. Each buffer row is also tagged with the lifetime of the data it holds. Short-lived query and attention-output activations are tagged transient. Key-value cache entries are tagged persistent.

The refresh policy depends on both the bit field and the lifetime. Sign-and-exponent rows are refreshed on the standard interval whatever their tag. Mantissa rows of persistent data are refreshed on a longer, relaxed interval. Mantissa rows of transient data are never refreshed.

A host allocates and frees rows by tag and reports writes, since a write restarts a row's retention window. A configuration port sets the two intervals. Refreshes leave the block one row at a time over a request/acknowledge handshake. Per-class counters of issued and skipped refreshes let the saving be measured.

Top module: `seg_refresh_ctrl`

## Requirements
- R1: `cfg_we` restarts both interval timers. The sign-and-exponent (segment 0) sweep then starts on every `std`-th clock edge, with `std` the standard interval in cycles. Each sweep issues one request for every valid, non-fresh row. The first request of a sweep is visible after the edge that follows the sweep start.
- R2: The mantissa (segment 1) sweep starts on every `rlx`-th edge after a configuration write, with `rlx` the relaxed interval in cycles. It issues one request for every valid, non-fresh persistent row (class 1).
- R3: A transient row (class 0) never receives a mantissa request. Each time the mantissa sweep passes a valid transient row, that row counts as one transient skip.
- R4: A configuration write stores the standard interval as `cfg_std`, or 1 when `cfg_std` is 0. It stores the relaxed interval as the larger of `cfg_rlx` and the stored standard interval.
- R5: A row that was never allocated, or that has been freed, receives no request in either segment. It is not counted as skipped.
- R6: `rf_req`, `rf_seg` and `rf_row` hold stable until `rf_ack` is seen, and `rf_req` drops on the next edge. When both segments want the output in the same cycle, segment 0 is served first.
- R7: A write to a valid row marks it fresh. A fresh row's next pass in the sign-and-exponent segment is skipped and counted as a skip in its class. For a persistent row, the next mantissa pass is also skipped and counted. A write to a transient row adds no mantissa request.
- R8: Bit 0 (segment 0) or bit 1 (segment 1) of `overdue` is set when that segment's interval expires while its previous sweep is still running. The bit stays set until reset.
- R9: `issued_t`/`issued_p` count requests loaded for transient/persistent rows. `skipped_t`/`skipped_p` count valid rows a sweep passed over without a request.
- R10: After reset there is no request, all counters and `overdue` are zero, and every row is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_en | input | 1 | Allocate row `alloc_row` |
| alloc_row | input | RW | Row to allocate |
| alloc_cls | input | 1 | Class of allocated row: 0 transient, 1 persistent |
| free_en | input | 1 | Free row `free_row` |
| free_row | input | RW | Row to free |
| wr_en | input | 1 | Data write to row `wr_row` |
| wr_row | input | RW | Written row |
| cfg_we | input | 1 | Load intervals and restart timers |
| cfg_std | input | IV_W | Standard interval in cycles |
| cfg_rlx | input | IV_W | Relaxed interval in cycles |
| rf_req | output | 1 | Refresh request |
| rf_seg | output | 1 | Segment: 0 sign/exponent, 1 mantissa |
| rf_row | output | RW | Row to refresh |
| rf_ack | input | 1 | Array accepted the request |
| overdue | output | 2 | Sticky overrun flag per segment |
| issued_t | output | STAT_W | Transient refreshes issued |
| issued_p | output | STAT_W | Persistent refreshes issued |
| skipped_t | output | STAT_W | Transient rows skipped |
| skipped_p | output | STAT_W | Persistent rows skipped |

## Verification
The timing follows from the edge that samples `cfg_we`. A sweep starts exactly `std` (or `rlx`) edges after that edge. Its first request is registered on the following edge. After an acknowledge, `rf_req` drops on the next edge and the next row is loaded one edge after that, so each issued row takes two edges and each skipped row takes one. The bench drives inputs and samples at falling edges. It counts edges from the configuration write to check the request's arrival on its exact edge. Counters and per-row tallies are compared only at points chosen between sweep completion and the next interval expiry, so no result depends on a partly finished sweep.

// File: rtl/seg_refresh_pkg.sv
// Shared encodings for the segmented refresh scheduler.
package seg_refresh_pkg;
    // Lifetime tag of a buffer row.
    typedef enum logic {
        CLS_TRANSIENT = 1'b0,
        CLS_PERSIST   = 1'b1
    } row_class_t;

    // Physical segment index; also the bit index in the overdue vector.
    localparam int unsigned SEG_SIGNEXP = 0;
    localparam int unsigned SEG_MANT    = 1;
    localparam int unsigned NUM_SEGS    = 2;
endpackage

// File: rtl/rfc_interval_timer.sv
// Free-running interval timer: pulses expire once every `period` cycles.
// Assumes period >= 1. A restart clears the count and suppresses expire.
module rfc_interval_timer #(
    parameter int unsigned IV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [IV_W-1:0] period,
    output logic            expire
);
    logic [IV_W-1:0] cnt;

    assign expire = !restart && (cnt >= period - IV_W'(1));

    // Count cycles, wrap on expiry or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart || expire) cnt <= '0;
        else                       cnt <= cnt + IV_W'(1);
    end
endmodule

// File: rtl/rfc_row_table.sv
// Per-row state: valid, class tag, and a fresh flag per segment.
// Fresh marks a row written since its last sweep visit; a visit clears it,
// a write in the same cycle wins. Mantissa fresh is only set on persistent rows.
module rfc_row_table
    import seg_refresh_pkg::*;
#(
    parameter int unsigned NROWS = 8,
    parameter int unsigned RW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [RW-1:0]    alloc_row,
    input  row_class_t       alloc_cls,
    input  logic             free_en,
    input  logic [RW-1:0]    free_row,
    input  logic             wr_en,
    input  logic [RW-1:0]    wr_row,
    input  logic [NROWS-1:0] clr_se,
    input  logic [NROWS-1:0] clr_mt,
    output logic [NROWS-1:0] row_valid,
    output logic [NROWS-1:0] row_persist,
    output logic [NROWS-1:0] fresh_se,
    output logic [NROWS-1:0] fresh_mt
);
    for (genvar r = 0; r < NROWS; r++) begin : g_row
        logic hit_alloc, hit_free, hit_wr;
        assign hit_alloc = alloc_en && (alloc_row == RW'(r));
        assign hit_free  = free_en  && (free_row  == RW'(r));
        assign hit_wr    = wr_en    && (wr_row    == RW'(r)) && row_valid[r];

        // Track allocation, class and freshness of row r.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_valid[r]   <= 1'b0;
                row_persist[r] <= 1'b0;
                fresh_se[r]    <= 1'b0;
                fresh_mt[r]    <= 1'b0;
            end else if (hit_alloc) begin
                row_valid[r]   <= 1'b1;
                row_persist[r] <= (alloc_cls == CLS_PERSIST);
                fresh_se[r]    <= 1'b0;
                fresh_mt[r]    <= 1'b0;
            end else if (hit_free) begin
                row_valid[r]   <= 1'b0;
                fresh_se[r]    <= 1'b0;
                fresh_mt[r]    <= 1'b0;
            end else begin
                if (hit_wr)         fresh_se[r] <= 1'b1;
                else if (clr_se[r]) fresh_se[r] <= 1'b0;
                if (hit_wr && row_persist[r]) fresh_mt[r] <= 1'b1;
                else if (clr_mt[r])           fresh_mt[r] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rfc_row_sweeper.sv
// One segment's sweep: on start walks rows 0..NROWS-1, one per cycle.
// An eligible row (valid, not fresh, class allowed) waits for a grant;
// any other row is passed at once. IS_MANT restricts eligibility to
// persistent rows. A start while busy is reported as overrun.
module rfc_row_sweeper #(
    parameter int unsigned NROWS   = 8,
    parameter int unsigned RW      = 3,
    parameter bit          IS_MANT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             grant,
    input  logic [NROWS-1:0] row_valid,
    input  logic [NROWS-1:0] row_persist,
    input  logic [NROWS-1:0] row_fresh,
    output logic             want,
    output logic             skip,
    output logic             skip_persist,
    output logic             overrun,
    output logic [RW-1:0]    cur_row,
    output logic [NROWS-1:0] clr
);
    localparam logic [RW-1:0] LAST = RW'(NROWS - 1);

    logic          busy;
    logic [RW-1:0] ptr;
    logic          class_ok, eligible, advance;

    if (IS_MANT) begin : g_mant
        assign class_ok = row_persist[ptr];
    end else begin : g_signexp
        assign class_ok = 1'b1;
    end

    assign eligible     = row_valid[ptr] && !row_fresh[ptr] && class_ok;
    assign want         = busy && eligible;
    assign advance      = busy && (!eligible || grant);
    assign skip         = busy && row_valid[ptr] && !eligible;
    assign skip_persist = row_persist[ptr];
    assign overrun      = start && busy;
    assign cur_row      = ptr;
    assign clr          = advance ? (NROWS'(1) << ptr) : '0;

    // Sweep state: begin on start, step on advance, stop after last row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            ptr  <= '0;
        end else if (advance) begin
            if (ptr == LAST) begin
                busy <= 1'b0;
                ptr  <= '0;
            end else begin
                ptr <= ptr + RW'(1);
            end
        end
    end
endmodule

// File: rtl/seg_refresh_ctrl.sv
// Top: two interval timers and two sweepers (sign/exponent, mantissa)
// share one request register toward the array; segment 0 wins ties.
// Holds the interval configuration, per-class statistics and sticky
// overdue flags. Assumes NROWS >= 2.
module seg_refresh_ctrl
    import seg_refresh_pkg::*;
#(
    parameter int unsigned NROWS   = 8,
    parameter int unsigned IV_W    = 16,
    parameter int unsigned STAT_W  = 16,
    parameter int unsigned DEF_STD = 1000,
    parameter int unsigned DEF_RLX = 4000,
    localparam int unsigned RW     = $clog2(NROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [RW-1:0]     alloc_row,
    input  logic              alloc_cls,
    input  logic              free_en,
    input  logic [RW-1:0]     free_row,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_row,
    input  logic              cfg_we,
    input  logic [IV_W-1:0]   cfg_std,
    input  logic [IV_W-1:0]   cfg_rlx,
    output logic              rf_req,
    output logic              rf_seg,
    output logic [RW-1:0]     rf_row,
    input  logic              rf_ack,
    output logic [1:0]        overdue,
    output logic [STAT_W-1:0] issued_t,
    output logic [STAT_W-1:0] issued_p,
    output logic [STAT_W-1:0] skipped_t,
    output logic [STAT_W-1:0] skipped_p
);
    logic [IV_W-1:0]     std_q, rlx_q, std_v, rlx_v;
    logic [NROWS-1:0]    row_valid, row_persist, fresh_se, fresh_mt;
    logic [NUM_SEGS-1:0] expire, want, grant, skip, skip_p, overrun;
    logic [RW-1:0]       cur_row [NUM_SEGS];
    logic [NROWS-1:0]    clr     [NUM_SEGS];
    logic [RW-1:0]       sel_row;
    logic                load;
    logic [1:0]          skip_t_n, skip_p_n;

    // Interval configuration with floor and ordering rules.
    assign std_v = (cfg_std == '0) ? IV_W'(1) : cfg_std;
    assign rlx_v = (cfg_rlx < std_v) ? std_v : cfg_rlx;

    // Register the intervals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_q <= IV_W'(DEF_STD);
            rlx_q <= IV_W'(DEF_RLX);
        end else if (cfg_we) begin
            std_q <= std_v;
            rlx_q <= rlx_v;
        end
    end

    rfc_row_table #(.NROWS(NROWS), .RW(RW)) i_table (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_row(alloc_row), .alloc_cls(row_class_t'(alloc_cls)),
        .free_en(free_en), .free_row(free_row),
        .wr_en(wr_en), .wr_row(wr_row),
        .clr_se(clr[SEG_SIGNEXP]), .clr_mt(clr[SEG_MANT]),
        .row_valid(row_valid), .row_persist(row_persist),
        .fresh_se(fresh_se), .fresh_mt(fresh_mt)
    );

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        logic [IV_W-1:0]  period;
        logic [NROWS-1:0] fresh_sel;
        assign period    = (g == SEG_MANT) ? rlx_q : std_q;
        assign fresh_sel = (g == SEG_MANT) ? fresh_mt : fresh_se;

        rfc_interval_timer #(.IV_W(IV_W)) i_timer (
            .clk(clk), .rst_n(rst_n), .restart(cfg_we),
            .period(period), .expire(expire[g])
        );

        rfc_row_sweeper #(.NROWS(NROWS), .RW(RW), .IS_MANT(g == SEG_MANT)) i_sweep (
            .clk(clk), .rst_n(rst_n), .start(expire[g]), .grant(grant[g]),
            .row_valid(row_valid), .row_persist(row_persist), .row_fresh(fresh_sel),
            .want(want[g]), .skip(skip[g]), .skip_persist(skip_p[g]),
            .overrun(overrun[g]), .cur_row(cur_row[g]), .clr(clr[g])
        );
    end

    // Fixed-priority arbitration onto the single request register.
    assign grant[SEG_SIGNEXP] = want[SEG_SIGNEXP] && !rf_req;
    assign grant[SEG_MANT]    = want[SEG_MANT] && !want[SEG_SIGNEXP] && !rf_req;
    assign load    = |grant;
    assign sel_row = want[SEG_SIGNEXP] ? cur_row[SEG_SIGNEXP] : cur_row[SEG_MANT];

    // Hold request until acknowledged, then free the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_req <= 1'b0;
            rf_seg <= 1'b0;
            rf_row <= '0;
        end else if (rf_req && rf_ack) begin
            rf_req <= 1'b0;
        end else if (load) begin
            rf_req <= 1'b1;
            rf_seg <= !want[SEG_SIGNEXP];
            rf_row <= sel_row;
        end
    end

    // Count skips per class this cycle across both sweepers.
    always_comb begin
        skip_t_n = '0;
        skip_p_n = '0;
        for (int g = 0; g < NUM_SEGS; g++) begin
            skip_t_n = skip_t_n + 2'(skip[g] && !skip_p[g]);
            skip_p_n = skip_p_n + 2'(skip[g] &&  skip_p[g]);
        end
    end

    // Statistics and sticky overdue flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_t  <= '0;
            issued_p  <= '0;
            skipped_t <= '0;
            skipped_p <= '0;
            overdue   <= '0;
        end else begin
            issued_t  <= issued_t  + STAT_W'(load && !row_persist[sel_row]);
            issued_p  <= issued_p  + STAT_W'(load &&  row_persist[sel_row]);
            skipped_t <= skipped_t + STAT_W'(skip_t_n);
            skipped_p <= skipped_p + STAT_W'(skip_p_n);
            overdue   <= overdue | overrun;
        end
    end
endmodule

// File: rtl/seg_refresh_ctrl_chk.sv
// Protocol and policy checker, bound into seg_refresh_ctrl.
// Keeps a one-cycle copy of the row table so a newly raised request is
// judged against the state it was loaded from.
module seg_refresh_ctrl_chk #(
    parameter int unsigned NROWS = 8,
    parameter int unsigned RW    = 3,
    parameter int unsigned IV_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rf_req,
    input logic             rf_ack,
    input logic             rf_seg,
    input logic [RW-1:0]    rf_row,
    input logic [NROWS-1:0] row_valid,
    input logic [NROWS-1:0] row_persist,
    input logic [1:0]       overdue,
    input logic [IV_W-1:0]  std_q,
    input logic [IV_W-1:0]  rlx_q
);
    logic [NROWS-1:0] valid_d, persist_d;

    // Delay row state by one cycle.
    always_ff @(posedge clk) begin
        valid_d   <= row_valid;
        persist_d <= row_persist;
    end

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_ack) |=> (rf_req && $stable(rf_row) && $stable(rf_seg)));

    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_ack) |=> !rf_req);

    p_no_transient_mant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rf_req) && rf_seg) |-> persist_d[rf_row]);

    p_valid_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_req) |-> valid_d[rf_row]);

    p_overdue_sticky0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overdue[0] |=> overdue[0]);

    p_overdue_sticky1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overdue[1] |=> overdue[1]);

    p_rlx_ge_std_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rlx_q >= std_q) && (std_q != '0));
endmodule

bind seg_refresh_ctrl seg_refresh_ctrl_chk #(.NROWS(NROWS), .RW(RW), .IV_W(IV_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .rf_req(rf_req), .rf_ack(rf_ack),
    .rf_seg(rf_seg), .rf_row(rf_row), .row_valid(row_valid),
    .row_persist(row_persist), .overdue(overdue), .std_q(std_q), .rlx_q(rlx_q)
);

// File: tb/test_seg_refresh_ctrl.sv
// Directed bench: one task per scenario, checks sampled at falling edges.
module test_seg_refresh_ctrl;
    localparam int NROWS = 8;
    localparam int RW    = 3;
    localparam int IV_W  = 16;
    localparam int SW    = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alloc_en = 0, alloc_cls = 0, free_en = 0, wr_en = 0, cfg_we = 0;
    logic [RW-1:0]   alloc_row = '0, free_row = '0, wr_row = '0;
    logic [IV_W-1:0] cfg_std = '0, cfg_rlx = '0;
    logic            rf_req, rf_seg, rf_ack;
    logic [RW-1:0]   rf_row;
    logic [1:0]      overdue;
    logic [SW-1:0]   issued_t, issued_p, skipped_t, skipped_p;

    int n_chk = 0, n_fail = 0;
    int cnt_se [NROWS];
    int cnt_mt [NROWS];
    int ack_delay = 0, hold = 0, stable_err = 0, first_seg = -1;
    logic [RW-1:0] hold_row;
    logic          hold_seg;
    bit            done = 0;

    always #5 clk = ~clk;

    seg_refresh_ctrl #(.NROWS(NROWS), .IV_W(IV_W), .STAT_W(SW)) i_seg_refresh_ctrl (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_row(alloc_row), .alloc_cls(alloc_cls),
        .free_en(free_en), .free_row(free_row), .wr_en(wr_en), .wr_row(wr_row),
        .cfg_we(cfg_we), .cfg_std(cfg_std), .cfg_rlx(cfg_rlx),
        .rf_req(rf_req), .rf_seg(rf_seg), .rf_row(rf_row), .rf_ack(rf_ack),
        .overdue(overdue), .issued_t(issued_t), .issued_p(issued_p),
        .skipped_t(skipped_t), .skipped_p(skipped_p)
    );

    // Array model: acknowledge after ack_delay cycles, tally by segment/row.
    initial begin
        rf_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rf_ack) rf_ack = 1'b0;
            else if (rf_req) begin
                if (hold == 0) begin
                    hold_row = rf_row;
                    hold_seg = rf_seg;
                end else if (rf_row != hold_row || rf_seg != hold_seg) begin
                    stable_err++;
                end
                if (hold >= ack_delay) begin
                    if (first_seg < 0) first_seg = int'(rf_seg);
                    if (rf_seg) cnt_mt[rf_row]++;
                    else        cnt_se[rf_row]++;
                    rf_ack = 1'b1;
                    hold = 0;
                end else begin
                    hold++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NROWS; i++) begin cnt_se[i] = 0; cnt_mt[i] = 0; end
        hold = 0; stable_err = 0; first_seg = -1;
        rst_n = 1'b1;
    endtask

    task automatic alloc(input int row, input bit cls);
        alloc_en = 1'b1; alloc_row = RW'(row); alloc_cls = cls;
        @(negedge clk);
        alloc_en = 1'b0;
    endtask

    // Configure; returns at the falling edge after the sampling edge (edge 0).
    task automatic configure(input int s, input int r);
        cfg_we = 1'b1; cfg_std = IV_W'(s); cfg_rlx = IV_W'(r);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(rf_req == 1'b0, "R10 req", rf_req, 0);
        chk(overdue == 2'b00, "R10 overdue", overdue, 0);
        chk((issued_t | issued_p | skipped_t | skipped_p) == '0, "R10 counters",
            issued_t + issued_p + skipped_t + skipped_p, 0);
        configure(5, 5);
        repeat (20) @(negedge clk);
        chk(issued_t + issued_p + skipped_t + skipped_p == 0, "R5 no rows no activity",
            issued_t + issued_p + skipped_t + skipped_p, 0);
    endtask

    task automatic t_main();
        do_reset();
        alloc(0, 1); alloc(1, 1); alloc(2, 0); alloc(3, 0);
        configure(20, 50);
        repeat (20) @(negedge clk);
        chk(rf_req == 1'b0, "R1 no request at sweep start", rf_req, 0);
        @(negedge clk);
        chk(rf_req == 1'b1 && rf_seg == 1'b0 && rf_row == 0, "R1 first request edge",
            {rf_req, rf_seg, rf_row}, 5'b10000);
        repeat (114) @(negedge clk);
        chk(cnt_se[0] == 6 && cnt_se[3] == 6, "R1 signexp per row", cnt_se[0] + cnt_se[3], 12);
        chk(cnt_mt[0] == 2 && cnt_mt[1] == 2, "R2 mantissa persistent", cnt_mt[0] + cnt_mt[1], 4);
        chk(cnt_mt[2] == 0 && cnt_mt[3] == 0, "R3 no transient mantissa", cnt_mt[2] + cnt_mt[3], 0);
        chk(cnt_se[4] + cnt_mt[7] == 0, "R5 invalid rows", cnt_se[4] + cnt_mt[7], 0);
        chk(issued_t == 12, "R9 issued_t", issued_t, 12);
        chk(issued_p == 16, "R9 issued_p", issued_p, 16);
        chk(skipped_t == 4, "R3 skipped_t", skipped_t, 4);
        chk(skipped_p == 0, "R9 skipped_p", skipped_p, 0);
        chk(overdue == 2'b00, "R8 no overdue", overdue, 0);
    endtask

    task automatic t_write();
        do_reset();
        alloc(0, 1); alloc(1, 0);
        configure(30, 60);
        repeat (9) @(negedge clk);
        wr_en = 1'b1; wr_row = 3'd0; @(negedge clk);
        wr_row = 3'd1; @(negedge clk);
        wr_en = 1'b0;
        repeat (34) @(negedge clk);
        chk(issued_t + issued_p == 0, "R7 fresh rows not refreshed", issued_t + issued_p, 0);
        chk(skipped_p == 1 && skipped_t == 1, "R7 fresh rows skipped", skipped_p + skipped_t, 2);
        repeat (40) @(negedge clk);
        chk(issued_t == 1 && issued_p == 1, "R7 refreshed next sweep", issued_t + issued_p, 2);
        chk(skipped_t == 2 && skipped_p == 2, "R7 skip totals", skipped_t + skipped_p, 4);
        chk(cnt_mt[1] == 0, "R7 transient write no mantissa", cnt_mt[1], 0);
        chk(cnt_mt[0] == 0 && cnt_se[0] == 1, "R7 persistent mantissa skipped", cnt_mt[0] + cnt_se[0], 1);
    endtask

    task automatic t_clamp();
        do_reset();
        alloc(0, 1);
        configure(40, 10);
        repeat (45) @(negedge clk);
        chk(cnt_mt[0] == 1, "R4 relaxed clamped to standard", cnt_mt[0], 1);
        chk(cnt_se[0] == 1, "R4 standard interval", cnt_se[0], 1);
    endtask

    task automatic t_overdue();
        do_reset();
        for (int i = 0; i < 4; i++) alloc(i, 1);
        ack_delay = 25;
        configure(10, 200);
        repeat (25) @(negedge clk);
        chk(overdue == 2'b01, "R8 overdue signexp", overdue, 1);
        chk(rf_req == 1'b1 && rf_row == 0 && rf_seg == 1'b0, "R6 request held",
            {rf_req, rf_seg, rf_row}, 5'b10000);
        repeat (15) @(negedge clk);
        chk(stable_err == 0, "R6 stable until ack", stable_err, 0);
        chk(cnt_se[0] == 1, "R6 one acknowledge", cnt_se[0], 1);
        chk(overdue == 2'b01, "R8 sticky", overdue, 1);
        ack_delay = 0;
    endtask

    task automatic t_free();
        do_reset();
        alloc(0, 1); alloc(1, 1);
        free_en = 1'b1; free_row = 3'd0; @(negedge clk);
        free_en = 1'b0;
        configure(20, 20);
        repeat (35) @(negedge clk);
        chk(cnt_se[0] + cnt_mt[0] == 0, "R5 freed row", cnt_se[0] + cnt_mt[0], 0);
        chk(cnt_se[1] == 1 && cnt_mt[1] == 1, "R2 valid row both segments", cnt_se[1] + cnt_mt[1], 2);
        chk(skipped_p + skipped_t == 0, "R5 freed not counted", skipped_p + skipped_t, 0);
        chk(issued_p == 2, "R9 issued_p", issued_p, 2);
        chk(first_seg == 0, "R6 signexp priority", first_seg, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_main();
        t_write();
        t_clamp();
        t_overdue();
        t_free();
        finish_run();
    end
endmodule